// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire serial link: a frame-enable line, a serial clock and one data line whose direction turns around inside the frame. All three lines are brought into the core clock domain by synchronizers, so the serial clock must run well below the core clock. The controller raises the enable line and toggles the clock. The block counts bits from the first falling clock edge and takes each data bit on a rising edge. It then decodes an 8-bit header: a direction flag, a 3-bit device identifier and a 4-bit address. Only headers that carry the identifier 110 are acted on.

A write frame is 16 bits long. The header is followed by one data byte, and that byte is stored into a 16-entry space of 8-bit registers. A read frame has the same header. From bit 8 onward the block turns the data line around and returns the addressed register, most significant bit first. Address 1111 holds a register that both banks share. Its two low bits choose which of two banks the remaining register addresses refer to. Addresses 0000 to 0011 belong to a separate sample FIFO. A read there becomes a 24-bit frame: the block asks the FIFO to load a word and then to shift it out one bit at a time. Internal logic sees each accepted write as a one-cycle strobe, and it sees the current bank's two control registers and the shared register as steady outputs.

Top module: `tri_wire_port`

## Requirements
- R1: Bit k of a frame begins at the k-th falling serial-clock edge (counting from 0) after the enable line rises. The data line is taken on the rising edge that follows. The header is ordered as read flag (1 = read), identifier bits 2..0, address bits 3..0, and is followed by data, most significant bit first.
- R2: A write frame that carries identifier 110 and has exactly 16 rising edges commits when the enable line falls. A one-cycle `wr_stb` carries the address and data, and the register takes the data.
- R3: A frame whose identifier is not 110 has no effect: no strobe, no register change, and the data line is never driven.
- R4: A write frame with fewer or more than 16 rising edges before the enable line falls is discarded.
- R5: On a valid read, `ser_oe` rises in bit 8 and `ser_dout` presents the addressed register most significant bit first. Each bit changes after a falling serial-clock edge.
- R6: `ser_oe` is low whenever the synchronized enable line is low. It drops within four core cycles after the enable line falls.
- R7: Address 1111 is a single register shared by both banks. Bank 1 is selected exactly when its bits 1:0 equal 01, and every other register address refers to separate storage in each bank.
- R8: After reset, address 0100 reads 0x40, address 0101 reads 0x63, address 1111 reads 0x20, bank 0 is selected, and all other register entries read 0x00.
- R9: A valid read of 0000 or 0010 pulses `fifo_load` once at the start of bit 8, with `fifo_sel` equal to address bit 1. It then pulses `fifo_shift` once at the start of each of bits 9 to 23, and `ser_dout` carries `fifo_bit` for bits 8 to 23.
- R10: A write to any address from 0000 to 0011 produces no strobe and changes nothing.
- R11: `wr_stb` only ever appears in the cycle directly after the synchronized enable line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Frame enable, high for the whole frame |
| ser_clk | input | 1 | Serial clock, rests high between frames |
| ser_din | input | 1 | Serial data from the controller |
| ser_dout | output | 1 | Serial data to the controller |
| ser_oe | output | 1 | Drive enable for the data line pad |
| wr_stb | output | 1 | One-cycle pulse for each accepted write |
| wr_addr | output | 4 | Address of the accepted write |
| wr_data | output | 8 | Data of the accepted write |
| wr_bank | output | 1 | Bank selected when the write was accepted |
| bank_sel | output | 1 | Bank currently selected |
| cfg_ctrl_a | output | 8 | Register 0100 of the current bank |
| cfg_ctrl_b | output | 8 | Register 0101 of the current bank |
| cfg_misc | output | 8 | Shared register 1111 |
| fifo_load | output | 1 | Ask the FIFO to load the selected word |
| fifo_sel | output | 1 | Word selected for the FIFO load |
| fifo_shift | output | 1 | Ask the FIFO to advance one bit |
| fifo_bit | input | 1 | Current bit from the FIFO |

## Verification
Some properties are checked on every cycle. The pad drive stays off while the synchronized enable line is low, and it is only on after a read header with a good identifier. Write strobes appear only right after the frame closes and never for a FIFO address. The bank select and the control outputs change only one cycle after a strobe, and FIFO load and shift pulses never coincide, with a load only at bit 8. Other behaviour needs whole frames and only the bench scenarios show it. These are the bit ordering, the exact data returned on a read, the rejection of a wrong identifier and of 15- or 17-bit frames, the separate storage behind the two banks, and the full FIFO load-and-shift sequence.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned AW         = 4;
  localparam int unsigned DW         = 8;
  localparam int unsigned IDW        = 3;
  localparam int unsigned NBANK      = 2;
  localparam int unsigned NREG       = 1 << AW;
  localparam int unsigned HDR_BITS   = 1 + IDW + AW;
  localparam int unsigned REG_FRAME  = HDR_BITS + DW;
  localparam int unsigned FIFO_WORD  = 2 * DW;
  localparam int unsigned FIFO_FRAME = HDR_BITS + FIFO_WORD;
  localparam int unsigned CNT_W      = $clog2(FIFO_FRAME + 2);
  localparam int unsigned SYNC_STAGES = 2;

  localparam logic [IDW-1:0] DEV_ID      = 3'b110;
  localparam logic [AW-1:0]  ADDR_CTRL_A = 4'h4;
  localparam logic [AW-1:0]  ADDR_CTRL_B = 4'h5;
  localparam logic [AW-1:0]  ADDR_MISC   = 4'hF;
  localparam logic [DW-1:0]  RST_CTRL_A  = 8'h40;
  localparam logic [DW-1:0]  RST_CTRL_B  = 8'h63;
  localparam logic [DW-1:0]  RST_MISC    = 8'h20;
  localparam logic [1:0]     BANK1_CODE  = 2'b01;

  typedef struct packed {
    logic            rd;
    logic [IDW-1:0]  id;
    logic [AW-1:0]   addr;
  } hdr_t;

  function automatic logic in_fifo_space(input logic [AW-1:0] a);
    return a[AW-1:2] == '0;
  endfunction

  function automatic logic [DW-1:0] rst_val(input logic [AW-1:0] a);
    case (a)
      ADDR_CTRL_A: return RST_CTRL_A;
      ADDR_CTRL_B: return RST_CTRL_B;
      ADDR_MISC:   return RST_MISC;
      default:     return '0;
    endcase
  endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] lvl
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_in;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign lvl = stg_q[STAGES-1];
endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx import tw_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_lvl,
  input  logic             en_rise,
  input  logic             en_fall,
  input  logic             sck_rise,
  input  logic             sdi,
  output hdr_t             hdr,
  output logic             hdr_seen,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             commit,
  output logic [AW-1:0]    commit_addr,
  output logic [DW-1:0]    commit_data
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    sh_q, sh_d;
  hdr_t             hdr_q, hdr_d;
  logic             commit_q, commit_d;
  logic [AW-1:0]    caddr_q, caddr_d;
  logic [DW-1:0]    cdata_q, cdata_d;
  logic             take_bit, wr_ok;

  assign take_bit = en_lvl && sck_rise;
  assign wr_ok    = (cnt_q == CNT_W'(REG_FRAME)) && !hdr_q.rd &&
                    (hdr_q.id == DEV_ID) && !in_fifo_space(hdr_q.addr);

  always_comb begin
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    hdr_d    = hdr_q;
    commit_d = 1'b0;
    caddr_d  = caddr_q;
    cdata_d  = cdata_q;
    if (en_rise) begin
      cnt_d = '0;
    end else if (take_bit) begin
      if (cnt_q < CNT_W'(REG_FRAME)) sh_d = {sh_q[DW-2:0], sdi};
      if (cnt_q == CNT_W'(HDR_BITS - 1))
        hdr_d = hdr_t'({sh_q[HDR_BITS-2:0], sdi});
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end
    if (en_fall && wr_ok) begin
      commit_d = 1'b1;
      caddr_d  = hdr_q.addr;
      cdata_d  = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      hdr_q    <= '0;
      commit_q <= 1'b0;
      caddr_q  <= '0;
      cdata_q  <= '0;
    end else begin
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      hdr_q    <= hdr_d;
      commit_q <= commit_d;
      caddr_q  <= caddr_d;
      cdata_q  <= cdata_d;
    end
  end

  assign hdr         = hdr_q;
  assign hdr_seen    = cnt_q >= CNT_W'(HDR_BITS);
  assign bit_cnt     = cnt_q;
  assign commit      = commit_q;
  assign commit_addr = caddr_q;
  assign commit_data = cdata_q;
endmodule

// File: rtl/tw_reg_store.sv
module tw_reg_store import tw_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          bank,
  output logic [DW-1:0] ctrl_a,
  output logic [DW-1:0] ctrl_b,
  output logic [DW-1:0] misc
);
  logic [DW-1:0] ent [NBANK][NREG];
  logic [DW-1:0] misc_q, misc_d;
  logic          misc_we;

  assign bank = (misc_q[1:0] == BANK1_CODE);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar a = 0; a < NREG; a++) begin : g_ent
      localparam logic [AW-1:0] A = AW'(a);
      if (A[AW-1:2] == '0 || A == ADDR_MISC) begin : g_none
        assign ent[b][a] = '0;
      end else begin : g_reg
        logic          we;
        logic [DW-1:0] q, d;
        assign we = wr_en && (wr_addr == A) && (bank == 1'(b));
        always_comb d = we ? wr_data : q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= rst_val(A);
          else        q <= d;
        end
        assign ent[b][a] = q;
      end
    end
  end

  assign misc_we = wr_en && (wr_addr == ADDR_MISC);
  always_comb misc_d = misc_we ? wr_data : misc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) misc_q <= RST_MISC;
    else        misc_q <= misc_d;
  end

  assign rd_data = (rd_addr == ADDR_MISC) ? misc_q : ent[bank][rd_addr];
  assign ctrl_a  = ent[bank][ADDR_CTRL_A];
  assign ctrl_b  = ent[bank][ADDR_CTRL_B];
  assign misc    = misc_q;
endmodule

// File: rtl/tw_tx_drive.sv
module tw_tx_drive import tw_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_lvl,
  input  logic             fall_evt,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             rd_ok,
  input  logic             from_fifo,
  input  logic             word_sel,
  input  logic [DW-1:0]    rd_data,
  input  logic             fifo_bit,
  output logic             dout,
  output logic             oe,
  output logic             fifo_load,
  output logic             fifo_shift,
  output logic             fifo_sel
);
  logic [DW-1:0] txsh_q, txsh_d;
  logic          take_q, take_d, take2_q, take2_d;
  logic          dout_q, dout_d, oe_q, oe_d;
  logic          load_q, load_d, shift_q, shift_d, sel_q, sel_d;
  logic          src_q, src_d;
  logic          start_bit;

  assign start_bit = fall_evt && rd_ok;

  always_comb begin
    txsh_d  = txsh_q;
    take_d  = 1'b0;
    take2_d = take_q;
    dout_d  = dout_q;
    oe_d    = oe_q;
    load_d  = 1'b0;
    shift_d = 1'b0;
    sel_d   = sel_q;
    src_d   = src_q;
    if (!en_lvl) begin
      oe_d    = 1'b0;
      dout_d  = 1'b0;
      take2_d = 1'b0;
    end else begin
      if (start_bit) begin
        take_d = 1'b1;
        if (bit_cnt == CNT_W'(HDR_BITS)) begin
          src_d = from_fifo;
          if (from_fifo) begin
            load_d = 1'b1;
            sel_d  = word_sel;
          end else begin
            txsh_d = rd_data;
          end
        end else if (src_q) begin
          shift_d = bit_cnt < CNT_W'(FIFO_FRAME);
        end else begin
          txsh_d = {txsh_q[DW-2:0], 1'b0};
        end
      end
      if (take2_q) begin
        oe_d   = 1'b1;
        dout_d = src_q ? fifo_bit : txsh_q[DW-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh_q  <= '0;
      take_q  <= 1'b0;
      take2_q <= 1'b0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
      load_q  <= 1'b0;
      shift_q <= 1'b0;
      sel_q   <= 1'b0;
      src_q   <= 1'b0;
    end else begin
      txsh_q  <= txsh_d;
      take_q  <= take_d;
      take2_q <= take2_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      load_q  <= load_d;
      shift_q <= shift_d;
      sel_q   <= sel_d;
      src_q   <= src_d;
    end
  end

  assign dout       = dout_q;
  assign oe         = oe_q;
  assign fifo_load  = load_q;
  assign fifo_shift = shift_q;
  assign fifo_sel   = sel_q;
endmodule

// File: rtl/tri_wire_port.sv
module tri_wire_port import tw_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_en,
  input  logic          ser_clk,
  input  logic          ser_din,
  output logic          ser_dout,
  output logic          ser_oe,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_bank,
  output logic          bank_sel,
  output logic [DW-1:0] cfg_ctrl_a,
  output logic [DW-1:0] cfg_ctrl_b,
  output logic [DW-1:0] cfg_misc,
  output logic          fifo_load,
  output logic          fifo_sel,
  output logic          fifo_shift,
  input  logic          fifo_bit
);
  logic [1:0]       rst_pipe;
  logic             rst_i;
  logic [2:0]       lines;
  logic             en_lvl, sck_lvl, sdi_lvl;
  logic [1:0]       prev_q, prev_d;
  logic             en_rise, en_fall, sck_rise, sck_fall;
  hdr_t             hdr;
  logic             hdr_seen, hdr_rd_ok;
  logic [CNT_W-1:0] bit_cnt;
  logic [DW-1:0]    rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  tw_line_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_i), .d_in({ser_din, ser_clk, ser_en}), .lvl(lines));

  assign en_lvl  = lines[0];
  assign sck_lvl = lines[1];
  assign sdi_lvl = lines[2];

  always_comb prev_d = {sck_lvl, en_lvl};
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) prev_q <= 2'b10;
    else        prev_q <= prev_d;
  end

  assign en_rise  =  en_lvl  && !prev_q[0];
  assign en_fall  = !en_lvl  &&  prev_q[0];
  assign sck_rise =  sck_lvl && !prev_q[1];
  assign sck_fall = !sck_lvl &&  prev_q[1];

  tw_frame_rx u_rx (
    .clk(clk), .rst_n(rst_i), .en_lvl(en_lvl), .en_rise(en_rise),
    .en_fall(en_fall), .sck_rise(sck_rise), .sdi(sdi_lvl),
    .hdr(hdr), .hdr_seen(hdr_seen), .bit_cnt(bit_cnt),
    .commit(wr_stb), .commit_addr(wr_addr), .commit_data(wr_data));

  assign hdr_rd_ok = hdr_seen && hdr.rd && (hdr.id == DEV_ID);

  tw_reg_store u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(hdr.addr), .rd_data(rd_data),
    .bank(bank_sel), .ctrl_a(cfg_ctrl_a), .ctrl_b(cfg_ctrl_b),
    .misc(cfg_misc));

  assign wr_bank = bank_sel;

  tw_tx_drive u_tx (
    .clk(clk), .rst_n(rst_i), .en_lvl(en_lvl),
    .fall_evt(sck_fall && en_lvl), .bit_cnt(bit_cnt), .rd_ok(hdr_rd_ok),
    .from_fifo(in_fifo_space(hdr.addr)), .word_sel(hdr.addr[1]),
    .rd_data(rd_data), .fifo_bit(fifo_bit), .dout(ser_dout), .oe(ser_oe),
    .fifo_load(fifo_load), .fifo_shift(fifo_shift), .fifo_sel(fifo_sel));
endmodule

// File: rtl/tw_port_chk.sv
module tw_port_chk import tw_pkg::*; (
  input logic             clk,
  input logic             rst_i,
  input logic             en_lvl,
  input logic             en_fall,
  input logic             ser_oe,
  input logic             hdr_rd_ok,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             wr_stb,
  input logic [AW-1:0]    wr_addr,
  input logic             bank_sel,
  input logic [DW-1:0]    cfg_ctrl_a,
  input logic             fifo_load,
  input logic             fifo_shift
);
  a_r6_oe_released: assert property (@(posedge clk) disable iff (!rst_i)
    !en_lvl |=> !ser_oe);

  a_r5_oe_after_read_hdr: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(ser_oe) |-> $past(hdr_rd_ok));

  a_r11_stb_at_close: assert property (@(posedge clk) disable iff (!rst_i)
    wr_stb |-> $past(en_fall));

  a_r10_no_fifo_write: assert property (@(posedge clk) disable iff (!rst_i)
    wr_stb |-> (wr_addr[AW-1:2] != '0));

  a_r7_bank_follows_write: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(bank_sel) |-> ($past(wr_stb) && $past(wr_addr) == ADDR_MISC));

  a_r2_cfg_follows_write: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(cfg_ctrl_a) |-> $past(wr_stb));

  a_r9_load_shift_apart: assert property (@(posedge clk) disable iff (!rst_i)
    !(fifo_load && fifo_shift));

  a_r9_load_at_bit8: assert property (@(posedge clk) disable iff (!rst_i)
    fifo_load |-> (bit_cnt == CNT_W'(HDR_BITS)));
endmodule

bind tri_wire_port tw_port_chk u_chk (
  .clk(clk), .rst_i(rst_i), .en_lvl(en_lvl), .en_fall(en_fall),
  .ser_oe(ser_oe), .hdr_rd_ok(hdr_rd_ok), .bit_cnt(bit_cnt),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .bank_sel(bank_sel),
  .cfg_ctrl_a(cfg_ctrl_a), .fifo_load(fifo_load), .fifo_shift(fifo_shift));

// File: tb/sim_tri_wire_port.sv
`timescale 1ns/1ps
module sim_tri_wire_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b1, ser_din = 1'b0;
  logic ser_dout, ser_oe, wr_stb, wr_bank, bank_sel;
  logic [3:0] wr_addr;
  logic [7:0] wr_data, cfg_ctrl_a, cfg_ctrl_b, cfg_misc;
  logic fifo_load, fifo_sel, fifo_shift, fifo_bit;

  always #2.5 clk = ~clk;

  tri_wire_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_oe(ser_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bank(wr_bank), .bank_sel(bank_sel), .cfg_ctrl_a(cfg_ctrl_a),
    .cfg_ctrl_b(cfg_ctrl_b), .cfg_misc(cfg_misc), .fifo_load(fifo_load),
    .fifo_sel(fifo_sel), .fifo_shift(fifo_shift), .fifo_bit(fifo_bit));

  localparam int HALF = 6;
  localparam logic [15:0] WORD0 = 16'hC3A5;
  localparam logic [15:0] WORD1 = 16'h5A0F;

  int errors = 0, checks = 0;
  bit done = 0;
  bit settle = 1;
  int en_low = 100;
  int n_stb = 0, n_load = 0, n_shift = 0;
  logic [3:0] last_addr;
  logic [7:0] last_data;
  logic last_sel;
  logic [15:0] fsh = '0;

  // behavioural model of the register space
  logic [7:0] m [2][16];
  logic [7:0] m_misc;

  function automatic bit mbank();
    return m_misc[1:0] == 2'b01;
  endfunction
  function automatic logic [7:0] mread(input logic [3:0] a);
    return (a == 4'hF) ? m_misc : m[mbank()][a];
  endfunction

  // neighbour FIFO model
  always @(posedge clk) begin
    if (fifo_load) begin
      fsh <= fifo_sel ? WORD1 : WORD0;
      n_load <= n_load + 1;
      last_sel <= fifo_sel;
    end else if (fifo_shift) begin
      fsh <= {fsh[14:0], 1'b0};
      n_shift <= n_shift + 1;
    end
  end
  assign fifo_bit = fsh[15];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      if (ser_en) en_low = 0; else if (en_low < 100) en_low++;
      if (en_low >= 4 && rst_n) chk("R6 oe idle", ser_oe, 0);
      if (wr_stb) begin
        n_stb++;
        last_addr = wr_addr;
        last_data = wr_data;
        chk("R11 strobe timing", (en_low >= 2 && en_low <= 5), 1);
      end
      if (!settle) begin
        chk("R7/R8 cfg_ctrl_a", cfg_ctrl_a, m[mbank()][4]);
        chk("R7/R8 cfg_ctrl_b", cfg_ctrl_b, m[mbank()][5]);
        chk("R7/R8 cfg_misc", cfg_misc, m_misc);
        chk("R7 bank_sel", bank_sel, mbank());
      end
    end
  end

  task automatic run_frame(input logic [23:0] vec, input int nb,
                           output logic [15:0] got, output int oe_first);
    got = '0;
    oe_first = -1;
    @(negedge clk);
    ser_en = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      ser_clk = 1'b0;
      ser_din = vec[nb-1-i];
      repeat (HALF) @(negedge clk);
      if (ser_oe && oe_first < 0) oe_first = i;
      if (i >= 8) got = {got[14:0], ser_dout};
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    ser_en = 1'b0;
    ser_din = 1'b0;
    settle = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d,
                          input logic [2:0] id, input int nb, input string req);
    logic [15:0] g;
    int of, s0;
    logic [23:0] v;
    bit ok;
    v = {8'h0, 1'b0, id, a, d};
    if (nb > 16) v = v << (nb - 16);
    else if (nb < 16) v = v >> (16 - nb);
    s0 = n_stb;
    run_frame(v, nb, g, of);
    ok = (id == 3'b110) && (nb == 16) && (a[3:2] != 2'b00);
    chk({req, " strobe count"}, n_stb - s0, ok ? 1 : 0);
    if (ok) begin
      chk({req, " strobe addr"}, last_addr, a);
      chk({req, " strobe data"}, last_data, d);
      if (a == 4'hF) m_misc = d; else m[mbank()][a] = d;
    end
    settle = 0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [2:0] id, input string req);
    logic [15:0] g;
    int of;
    run_frame({8'h0, 1'b1, id, a, 8'h00}, 16, g, of);
    if (id == 3'b110) begin
      chk({req, " oe starts bit 8"}, of, 8);
      chk({req, " read data"}, g[7:0], mread(a));
    end else begin
      chk({req, " oe never driven"}, of, -1);
    end
    settle = 0;
  endtask

  task automatic do_fifo(input logic [3:0] a, input string req);
    logic [15:0] g;
    int of, l0, s0;
    l0 = n_load;
    s0 = n_shift;
    run_frame({1'b1, 3'b110, a, 16'h0}, 24, g, of);
    chk({req, " load count"}, n_load - l0, 1);
    chk({req, " shift count"}, n_shift - s0, 15);
    chk({req, " word select"}, last_sel, a[1]);
    chk({req, " oe starts bit 8"}, of, 8);
    chk({req, " fifo data"}, g, a[1] ? WORD1 : WORD0);
    settle = 0;
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 16; a++) m[b][a] = 8'h00;
    m[0][4] = 8'h40; m[1][4] = 8'h40;
    m[0][5] = 8'h63; m[1][5] = 8'h63;
    m_misc = 8'h20;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // R8 reset state
    chk("R8 reset ctrl_a", cfg_ctrl_a, 8'h40);
    chk("R8 reset ctrl_b", cfg_ctrl_b, 8'h63);
    chk("R8 reset misc", cfg_misc, 8'h20);
    chk("R8 reset bank", bank_sel, 0);
    chk("R6 reset oe", ser_oe, 0);
    settle = 0;
    do_read(4'h5, 3'b110, "R8 read 0101");
    do_read(4'h9, 3'b110, "R8 read 1001");
    // R1 R2 R5 basic write and read back
    do_write(4'h8, 8'hA5, 3'b110, 16, "R2 write 1000");
    do_read(4'h8, 3'b110, "R5 R1 read 1000");
    do_write(4'h4, 8'h3C, 3'b110, 16, "R2 write 0100");
    chk("R2 ctrl_a updated", cfg_ctrl_a, 8'h3C);
    do_write(4'hB, 8'h81, 3'b110, 16, "R2 write 1011");
    do_read(4'hB, 3'b110, "R5 read 1011");
    // R3 identifier mismatch
    do_write(4'h8, 8'h11, 3'b101, 16, "R3 bad id write");
    do_write(4'h8, 8'h22, 3'b010, 16, "R3 bad id write");
    do_read(4'h8, 3'b011, "R3 bad id read");
    do_read(4'h8, 3'b110, "R3 value kept");
    // R4 length
    do_write(4'h8, 8'h33, 3'b110, 15, "R4 short frame");
    do_write(4'h8, 8'h44, 3'b110, 17, "R4 long frame");
    do_read(4'h8, 3'b110, "R4 value kept");
    // R10 FIFO space writes
    do_write(4'h2, 8'h77, 3'b110, 16, "R10 write 0010");
    do_write(4'h0, 8'h55, 3'b110, 16, "R10 write 0000");
    // R9 FIFO reads
    do_fifo(4'h0, "R9 fifo 0000");
    do_fifo(4'h2, "R9 fifo 0010");
    // R7 banks
    do_write(4'hF, 8'h21, 3'b110, 16, "R7 select bank 1");
    chk("R7 bank 1 selected", bank_sel, 1);
    do_read(4'h8, 3'b110, "R7 bank1 1000");
    do_write(4'h8, 8'h5A, 3'b110, 16, "R7 bank1 write");
    do_read(4'h8, 3'b110, "R7 bank1 1000 after");
    do_read(4'hF, 3'b110, "R7 shared 1111");
    do_write(4'hF, 8'h23, 3'b110, 16, "R7 code 11 is bank 0");
    chk("R7 bank 0 for 11", bank_sel, 0);
    do_read(4'h8, 3'b110, "R7 bank0 1000");
    do_write(4'hF, 8'h20, 3'b110, 16, "R7 back to bank 0");
    do_read(4'h4, 3'b110, "R7 bank0 0100");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule